// File: doc/BRIEF.md
# Dual-Image Reconfiguration Control Registers

This block is a small write-decoded register slave that lets plain user logic, with no processor, choose which of two stored configuration images the device loads next, and then start the reload. A controller first places the new image in flash. It then writes an image choice and an override enable into one register word, and finally writes a reload command into another word. The same command word also carries a request to restart an external watchdog. Command pulses are combinational and appear in the same cycle as the write that asks for them.

An accepted image-choice write is copied into a modelled configuration-select port. The copy takes a parameterised number of cycles, and a busy flag covers that time. Image-choice writes that arrive while busy is high are dropped. A reload request that arrives while busy is high is held back. It is issued one cycle after busy clears, so the reload always sees the new choice. An effective image-select output shows which image would load: the external pin when the override is off, and the latched register bit when it is on.

Top module: `rcfg_ctrl_regs`

## Requirements
- R1: A write to word 0 with bit 0 set, while busy is low, raises `reconfig_pulse` for exactly that cycle. Bits 31:2 of a word 0 write have no effect on any output.
- R2: A write to word 0 with bit 1 set raises `wdog_rst_pulse` in that same cycle, whether or not busy is high. If bits 0 and 1 are both set while busy is low, both pulses rise together in that cycle.
- R3: A write to word 1 while busy is low latches data bit 0 as the override enable and data bit 1 as the image select. Reading word 1 returns busy in bit 0, the override enable in bit 1, the image select in bit 2, and zero in every other bit. A read of any other word returns zero.
- R4: After an accepted word 1 write, busy is high for exactly XFER_CYCLES cycles (4 by default), starting in the cycle after the write.
- R5: A word 1 write made in a cycle where busy is high changes neither the latched values nor busy.
- R6: `eff_image_sel` equals `pin_image_sel` when the latched override enable is 0, and equals the latched image select when it is 1.
- R7: A reload request (word 0, bit 0) made while busy is high gives no pulse at that time. It gives a single-cycle `reconfig_pulse` in the second cycle in which busy is low.
- R8: `cfg_ovr_en` and `cfg_image_sel` take the latched values at the clock edge where busy falls, and do not change at any other time.
- R9: While the synchronous active-high `rst` is high, both pulses are low. After `rst` the override enable, image select, busy, any pending reload and the configuration-port values are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the combinational read |
| rd_data | output | DATA_W | Read data |
| pin_image_sel | input | 1 | External image-select pin |
| reconfig_pulse | output | 1 | Single-cycle reload trigger |
| wdog_rst_pulse | output | 1 | Single-cycle watchdog restart |
| busy | output | 1 | Selection transfer in progress |
| eff_image_sel | output | 1 | Image that would load next |
| cfg_ovr_en | output | 1 | Override enable as seen by the configuration port |
| cfg_image_sel | output | 1 | Image select as seen by the configuration port |

## Verification
Two pairs of functions can fall in the same cycle. A word 0 write with both low bits set must fire the reload and the watchdog restart together. A deferred reload must sit next to the fall of busy and to a fresh image-choice write that lands right at that edge. The bench provokes these cases directly. It writes 0x3 while idle and while busy, and it writes word 1 exactly in the last busy cycle and again in the first idle cycle. On every clock it compares each output against a behavioural model that keeps its own countdown, its pending-reload flag and its latched copies.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

    parameter int unsigned REG_W = 32;

    localparam int unsigned CMD_WORD = 0;
    localparam int unsigned SEL_WORD = 1;

    localparam int unsigned CMD_RECONF_BIT = 0;
    localparam int unsigned CMD_WDOG_BIT   = 1;
    localparam int unsigned SEL_OVR_BIT    = 0;
    localparam int unsigned SEL_IMG_BIT    = 1;

    localparam int unsigned STS_BUSY_BIT = 0;
    localparam int unsigned STS_OVR_BIT  = 1;
    localparam int unsigned STS_IMG_BIT  = 2;

    typedef struct packed {
        logic reconf_req;
        logic wdog_req;
        logic sel_wr;
        logic ovr_bit;
        logic img_bit;
    } wr_cmd_t;

    typedef struct packed {
        logic img;
        logic ovr;
        logic busy;
    } status_t;

    function automatic logic [2:0] pack_status(input status_t s);
        logic [2:0] v;
        v = '0;
        v[STS_BUSY_BIT] = s.busy;
        v[STS_OVR_BIT]  = s.ovr;
        v[STS_IMG_BIT]  = s.img;
        return v;
    endfunction

endpackage

// File: rtl/rcfg_wr_decode.sv
module rcfg_wr_decode
    import rcfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cmd_t           cmd
);

    localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_WORD);
    localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_WORD);

    logic hit_cmd;
    logic hit_sel;
    logic unused_hi;

    assign hit_cmd   = wr_en && (wr_addr == CMD_A);
    assign hit_sel   = wr_en && (wr_addr == SEL_A);
    assign unused_hi = ^wr_data[DATA_W-1:2];

    always_comb begin
        cmd            = '0;
        cmd.reconf_req = hit_cmd && wr_data[CMD_RECONF_BIT];
        cmd.wdog_req   = hit_cmd && wr_data[CMD_WDOG_BIT];
        cmd.sel_wr     = hit_sel;
        cmd.ovr_bit    = wr_data[SEL_OVR_BIT];
        cmd.img_bit    = wr_data[SEL_IMG_BIT];
    end

endmodule

// File: rtl/rcfg_sel_xfer.sv
module rcfg_sel_xfer #(
    parameter int unsigned XFER_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_wr,
    input  logic ovr_bit,
    input  logic img_bit,
    output logic busy,
    output logic ovr_q,
    output logic img_q,
    output logic cfg_ovr,
    output logic cfg_img
);

    localparam int unsigned CNT_W = $clog2(XFER_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(XFER_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    assign busy   = (cnt_q != '0);
    assign accept = sel_wr && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovr_q <= 1'b0;
            img_q <= 1'b0;
        end else if (accept) begin
            cnt_q <= LOAD;
            ovr_q <= ovr_bit;
            img_q <= img_bit;
        end else if (busy) begin
            cnt_q <= cnt_q - LAST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_ovr <= 1'b0;
            cfg_img <= 1'b0;
        end else if (cnt_q == LAST) begin
            cfg_ovr <= ovr_q;
            cfg_img <= img_q;
        end
    end

    assert_busy_from_write_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(sel_wr));

    assert_drop_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable({ovr_q, img_q}));

    assert_cfg_at_fall_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable({cfg_ovr, cfg_img}) |-> $fell(busy));

endmodule

// File: rtl/rcfg_pulse_gen.sv
module rcfg_pulse_gen (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic reconf_req,
    input  logic wdog_req,
    output logic reconfig_pulse,
    output logic wdog_pulse
);

    logic pend_q;
    logic fire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            fire_q <= 1'b0;
        end else begin
            pend_q <= busy && (pend_q || reconf_req);
            fire_q <= !busy && pend_q;
        end
    end

    assign reconfig_pulse = !rst && ((reconf_req && !busy) || fire_q);
    assign wdog_pulse     = !rst && wdog_req;

    assert_deferred_after_idle_R7: assert property (@(posedge clk) disable iff (rst)
        fire_q |-> !$past(busy));

    assert_deferred_single_R7: assert property (@(posedge clk) disable iff (rst)
        fire_q |=> !fire_q);

endmodule

// File: rtl/rcfg_ctrl_regs.sv
module rcfg_ctrl_regs
    import rcfg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = REG_W,
    parameter int unsigned XFER_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pin_image_sel,
    output logic              reconfig_pulse,
    output logic              wdog_rst_pulse,
    output logic              busy,
    output logic              eff_image_sel,
    output logic              cfg_ovr_en,
    output logic              cfg_image_sel
);

    localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_WORD);

    wr_cmd_t cmd;
    status_t sts;
    logic    ovr_q;
    logic    img_q;

    rcfg_wr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    rcfg_sel_xfer #(.XFER_CYCLES(XFER_CYCLES)) u_xfer (
        .clk     (clk),
        .rst     (rst),
        .sel_wr  (cmd.sel_wr),
        .ovr_bit (cmd.ovr_bit),
        .img_bit (cmd.img_bit),
        .busy    (busy),
        .ovr_q   (ovr_q),
        .img_q   (img_q),
        .cfg_ovr (cfg_ovr_en),
        .cfg_img (cfg_image_sel)
    );

    rcfg_pulse_gen u_pulse (
        .clk            (clk),
        .rst            (rst),
        .busy           (busy),
        .reconf_req     (cmd.reconf_req),
        .wdog_req       (cmd.wdog_req),
        .reconfig_pulse (reconfig_pulse),
        .wdog_pulse     (wdog_rst_pulse)
    );

    assign eff_image_sel = ovr_q ? img_q : pin_image_sel;

    always_comb begin
        sts.busy = busy;
        sts.ovr  = ovr_q;
        sts.img  = img_q;
        rd_data  = '0;
        if (rd_addr == SEL_A) rd_data[2:0] = pack_status(sts);
    end

    assert_both_pulses_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0 && wr_data[1:0] == 2'b11 && !busy)
            |-> (reconfig_pulse && wdog_rst_pulse));

    assert_override_mux_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_data[STS_OVR_BIT] && rd_addr == SEL_A |-> eff_image_sel == pin_image_sel);

endmodule

// File: tb/rcfg_ctrl_regs_tb.sv
module rcfg_ctrl_regs_tb;

    localparam int CLK_P = 10;
    localparam int XFER  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = 4'd1;
    logic [31:0] rd_data;
    logic        pin_image_sel = 1'b0;
    logic        reconfig_pulse, wdog_rst_pulse, busy, eff_image_sel;
    logic        cfg_ovr_en, cfg_image_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int m_cnt = 0;
    bit m_ovr = 0, m_sel = 0, m_pend = 0, m_fire = 0, m_cfg_ovr = 0, m_cfg_sel = 0;

    always #(CLK_P/2) clk = ~clk;

    rcfg_ctrl_regs u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_image_sel(pin_image_sel),
        .reconfig_pulse(reconfig_pulse), .wdog_rst_pulse(wdog_rst_pulse), .busy(busy),
        .eff_image_sel(eff_image_sel), .cfg_ovr_en(cfg_ovr_en), .cfg_image_sel(cfg_image_sel)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic step(input bit r, input bit w, input int a, input logic [31:0] d,
                        input int ra, input bit p);
        bit m_busy, imm, acc, e_rec, e_wd, e_eff;
        logic [31:0] e_rd;
        rst = r; wr_en = w; wr_addr = 4'(a); wr_data = d; rd_addr = 4'(ra); pin_image_sel = p;
        #1;
        m_busy = (m_cnt != 0);
        imm    = w && a == 0 && d[0];
        acc    = w && a == 1 && !m_busy;
        e_rec  = !r && ((imm && !m_busy) || m_fire);
        e_wd   = !r && w && a == 0 && d[1];
        e_eff  = m_ovr ? m_sel : p;
        e_rd   = (ra == 1) ? {29'd0, m_sel, m_ovr, m_busy} : 32'd0;
        chk(reconfig_pulse, e_rec, r ? "R9" : "R1/R7", "reconfig_pulse");
        chk(wdog_rst_pulse, e_wd, r ? "R9" : "R2", "wdog_rst_pulse");
        chk(busy, m_busy, "R4", "busy");
        chk(rd_data, e_rd, "R3/R5", "rd_data");
        chk(eff_image_sel, e_eff, "R6", "eff_image_sel");
        chk({cfg_ovr_en, cfg_image_sel}, {m_cfg_ovr, m_cfg_sel}, "R8", "cfg port");
        if (r) begin
            m_cnt = 0; m_ovr = 0; m_sel = 0; m_pend = 0; m_fire = 0; m_cfg_ovr = 0; m_cfg_sel = 0;
        end else begin
            m_fire = !m_busy && m_pend;
            m_pend = m_busy && (m_pend || imm);
            if (m_cnt == 1) begin m_cfg_ovr = m_ovr; m_cfg_sel = m_sel; end
            if (acc) begin m_cnt = XFER; m_ovr = d[0]; m_sel = d[1]; end
            else if (m_cnt > 0) m_cnt--;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit p);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, p);
    endtask

    initial begin
        @(negedge clk);
        // R9: reset state and pulse suppression
        step(1, 1, 0, 32'h3, 1, 0);
        step(1, 0, 0, 0, 1, 0);
        idle(2, 0);
        // R1: single reload pulse; R2: watchdog alone and both together
        step(0, 1, 0, 32'h1, 1, 0);
        step(0, 1, 0, 32'h2, 1, 0);
        step(0, 1, 0, 32'h3, 1, 0);
        // R1: upper bits ignored
        step(0, 1, 0, 32'hFFFF_FFFC, 1, 0);
        // R6: pin passes through with override off
        step(0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1, 0);
        // R3/R4: accept word 1 write, override on, image 1
        step(0, 1, 1, 32'h3, 1, 0);
        // R5: dropped write; R7: deferred reload; R2 during busy
        step(0, 1, 1, 32'h0, 1, 1);
        step(0, 1, 0, 32'h1, 1, 0);
        step(0, 1, 0, 32'h2, 1, 0);
        step(0, 1, 1, 32'h0, 1, 0);
        idle(4, 1);
        // R3: other words read zero
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 5, 0);
        // R5 boundary: write at the last busy cycle dropped, next one accepted
        step(0, 1, 1, 32'h2, 1, 0);
        idle(3, 1);
        step(0, 1, 1, 32'h1, 1, 1);
        step(0, 1, 1, 32'h1, 1, 1);
        step(0, 1, 0, 32'h3, 1, 0);
        idle(3, 1);
        step(0, 1, 1, 32'h0, 1, 1);
        idle(6, 1);
        idle(2, 0);
        // R9: reset in the middle of a transfer with a reload pending
        step(0, 1, 1, 32'h3, 1, 0);
        step(0, 1, 0, 32'h1, 1, 0);
        step(1, 0, 0, 0, 1, 1);
        idle(6, 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule